// File: doc/BRIEF.md
# PCIe Link Power State Sequencer

This block decides which link power state an endpoint is in. It works from two kinds of input. The first is the state of the functions: a level that is high while every enabled function is in D3hot. The second is the power-management traffic around the link: a strobe for a received turn-off message, wake requests from the functions, a transfer-pending hint, and host-initiated exit events such as retrain, link disable and hot reset. It reports the resulting state as a 3-bit code. It also raises one-cycle requests that ask the transmit path to send a turn-off acknowledge message and an enter-L23 DLLP.

While D3 holds, the link drops into L1. It wakes to L0 when a function returns to D0, a host event occurs, a function asks to wake, or a transfer is pending. It falls back into L1 as soon as D3 still holds. A turn-off message starts a shutdown that runs without further input. The block acknowledges the message at once, then waits for the application's level-sensitive ready input, then requests L23 entry and parks in L2/L3 Ready until reset. There is no data stream through the block, so every pin is a plain control or status signal with no back-pressure.

Top module: `lpm_link_seq`

## Requirements
- R1: After reset the link code is 000 and both request outputs are low. The codes used are: 000 for L0 (also during shutdown), 010 for L1, and 100 for L2/L3 Ready. The L2/L3 Ready code becomes 011 when the auxiliary-power parameter is set. No other code appears.
- R2: In L0, a sampled high on the all-functions-in-D3 input with no turn-off strobe gives code 010 on the next cycle.
- R3: In L1, any of the following gives code 000 on the next cycle: the all-functions-in-D3 input low, any host exit event bit high, or any function wake bit high.
- R4: A turn-off strobe sampled in L0 or L1 raises the acknowledge request on the next cycle with code 000. The request lasts exactly one cycle.
- R5: After the acknowledge cycle, the enter-L23 request stays low while the ready input is low. Once ready is sampled high in the waiting phase, the request goes high on the next cycle. With ready already high, it comes two cycles after the acknowledge cycle.
- R6: The enter-L23 request lasts one cycle. On the next cycle the code is the L2/L3 Ready code, and it stays there whatever the inputs do until reset.
- R7: In L1, a transfer-pending high gives code 000 on the next cycle. If D3 still holds, the code returns to 010 one cycle later.
- R8: In L0, transfer-pending has no effect: L1 is still entered one cycle after D3 is sampled.
- R9: From the acknowledge cycle until the enter-L23 request, the code stays 000 and no further acknowledge is raised. D3, wake, host-event and repeated turn-off inputs are all ignored in this span.
- R10: In L1, a turn-off strobe takes priority over exit events sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; stands in for a power cycle |
| all_d3_i | input | 1 | High while all enabled functions are in D3hot |
| turnoff_rx_i | input | 1 | One-cycle strobe: turn-off message received |
| l23_ready_i | input | 1 | Level: application ready for L2/L3 entry |
| xfer_pend_i | input | 1 | Transfer-pending hint, acted on only in L1 |
| host_evt_i | input | NUM_HOST_EVT | Host exit events (retrain, disable, hot reset) |
| wake_req_i | input | NUM_FUNC | Per-function wake (PME) requests |
| link_state_o | output | 3 | Link power state code |
| ack_tx_o | output | 1 | One-cycle request to send turn-off acknowledge |
| enter_l23_o | output | 1 | One-cycle request to send enter-L23 DLLP |

## Verification
Each wrong internal state shows at the ports within one or two cycles. A stuck or wrongly chosen state shows up as a wrong code on the cycle after the deciding input was sampled. A missed return to L1 shows up one cycle later still. A shutdown sequence that is skipped or repeated shows up in three ways: a missing or doubled one-cycle request, a request that appears while the ready input is low, or a terminal code that moves before reset. The directed scenarios sample one cycle after each stimulus, so any of these is caught in the cycle where it first appears.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] CODE_L0  = 3'b000;
  localparam logic [CODE_W-1:0] CODE_L1  = 3'b010;
  localparam logic [CODE_W-1:0] CODE_L2  = 3'b011;
  localparam logic [CODE_W-1:0] CODE_L3  = 3'b100;

  typedef enum logic [2:0] {
    ST_L0    = 3'd0,
    ST_L1    = 3'd1,
    ST_ACK   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_ENTER = 3'd4,
    ST_L23   = 3'd5
  } lseq_state_t;
endpackage

// File: rtl/lpm_exit_merge.sv
module lpm_exit_merge #(
  parameter int NUM_FUNC     = 8,
  parameter int NUM_HOST_EVT = 3
) (
  input  logic                    all_d3_i,
  input  logic                    xfer_pend_i,
  input  logic [NUM_HOST_EVT-1:0] host_evt_i,
  input  logic [NUM_FUNC-1:0]     wake_req_i,
  output logic                    leave_l1_o
);
  logic any_host;
  logic any_wake;

  assign any_host   = |host_evt_i;
  assign any_wake   = |wake_req_i;
  assign leave_l1_o = !all_d3_i || any_host || any_wake || xfer_pend_i;
endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        all_d3_i,
  input  logic        turnoff_rx_i,
  input  logic        l23_ready_i,
  input  logic        leave_l1_i,
  output lseq_state_t state_o,
  output logic        ack_tx_o,
  output logic        enter_l23_o
);
  lseq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_L0: begin
        if (turnoff_rx_i)  state_d = ST_ACK;
        else if (all_d3_i) state_d = ST_L1;
      end
      ST_L1: begin
        if (turnoff_rx_i)    state_d = ST_ACK;
        else if (leave_l1_i) state_d = ST_L0;
      end
      ST_ACK:   state_d = ST_WAIT;
      ST_WAIT:  if (l23_ready_i) state_d = ST_ENTER;
      ST_ENTER: state_d = ST_L23;
      ST_L23:   state_d = ST_L23;
      default:  state_d = ST_L0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_L0;
    else        state_q <= state_d;
  end

  assign state_o     = state_q;
  assign ack_tx_o    = (state_q == ST_ACK);
  assign enter_l23_o = (state_q == ST_ENTER);
endmodule

// File: rtl/lpm_code_enc.sv
module lpm_code_enc
  import lpm_pkg::*;
#(
  parameter bit AUX_PRESENT = 1'b0
) (
  input  lseq_state_t       state_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] park_code;

  generate
    if (AUX_PRESENT) begin : g_aux
      assign park_code = CODE_L2;
    end else begin : g_noaux
      assign park_code = CODE_L3;
    end
  endgenerate

  always_comb begin
    unique case (state_i)
      ST_L1:   code_o = CODE_L1;
      ST_L23:  code_o = park_code;
      default: code_o = CODE_L0;
    endcase
  end
endmodule

// File: rtl/lpm_link_seq.sv
module lpm_link_seq
  import lpm_pkg::*;
#(
  parameter int NUM_FUNC     = 8,
  parameter int NUM_HOST_EVT = 3,
  parameter bit AUX_PRESENT  = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    all_d3_i,
  input  logic                    turnoff_rx_i,
  input  logic                    l23_ready_i,
  input  logic                    xfer_pend_i,
  input  logic [NUM_HOST_EVT-1:0] host_evt_i,
  input  logic [NUM_FUNC-1:0]     wake_req_i,
  output logic [2:0]              link_state_o,
  output logic                    ack_tx_o,
  output logic                    enter_l23_o
);
  localparam logic [CODE_W-1:0] PARK_CODE = AUX_PRESENT ? CODE_L2 : CODE_L3;

  logic        leave_l1;
  lseq_state_t st_w;

  lpm_exit_merge #(
    .NUM_FUNC    (NUM_FUNC),
    .NUM_HOST_EVT(NUM_HOST_EVT)
  ) u_merge (
    .all_d3_i   (all_d3_i),
    .xfer_pend_i(xfer_pend_i),
    .host_evt_i (host_evt_i),
    .wake_req_i (wake_req_i),
    .leave_l1_o (leave_l1)
  );

  lpm_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .all_d3_i    (all_d3_i),
    .turnoff_rx_i(turnoff_rx_i),
    .l23_ready_i (l23_ready_i),
    .leave_l1_i  (leave_l1),
    .state_o     (st_w),
    .ack_tx_o    (ack_tx_o),
    .enter_l23_o (enter_l23_o)
  );

  lpm_code_enc #(
    .AUX_PRESENT(AUX_PRESENT)
  ) u_enc (
    .state_i(st_w),
    .code_o (link_state_o)
  );
endmodule

// File: rtl/lpm_link_seq_chk.sv
module lpm_link_seq_chk
  import lpm_pkg::*;
#(
  parameter logic [2:0] PARK = 3'b100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       all_d3_i,
  input logic       turnoff_rx_i,
  input logic       l23_ready_i,
  input logic       xfer_pend_i,
  input logic [2:0] st,
  input logic [2:0] link_state_o,
  input logic       ack_tx_o,
  input logic       enter_l23_o
);
  // R1: only defined codes appear
  assert_code_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state_o == CODE_L0) || (link_state_o == CODE_L1) || (link_state_o == PARK));

  assert_enter_l1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_L0 && all_d3_i && !turnoff_rx_i) |=> (link_state_o == CODE_L1));

  assert_ack_after_turnoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_L0 || st == ST_L1) && turnoff_rx_i) |=> (ack_tx_o && link_state_o == CODE_L0));

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_tx_o |=> !ack_tx_o);

  assert_hold_l23_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !l23_ready_i) |=> !enter_l23_o);

  assert_enter_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enter_l23_o |=> (!enter_l23_o && link_state_o == PARK));

  assert_park_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_L23) |=> $stable(link_state_o));

  assert_xfer_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_L1 && xfer_pend_i && !turnoff_rx_i) |=> (link_state_o == CODE_L0));

  assert_wait_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |=> (!ack_tx_o && link_state_o == CODE_L0));
endmodule

bind lpm_link_seq lpm_link_seq_chk #(.PARK(PARK_CODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .all_d3_i    (all_d3_i),
  .turnoff_rx_i(turnoff_rx_i),
  .l23_ready_i (l23_ready_i),
  .xfer_pend_i (xfer_pend_i),
  .st          (st_w),
  .link_state_o(link_state_o),
  .ack_tx_o    (ack_tx_o),
  .enter_l23_o (enter_l23_o)
);

// File: tb/sim_lpm_link_seq.sv
`timescale 1ns/1ps
module sim_lpm_link_seq;
  localparam int NF = 8;
  localparam int NH = 3;
  localparam logic [2:0] C_L0  = 3'b000;
  localparam logic [2:0] C_L1  = 3'b010;
  localparam logic [2:0] C_L23 = 3'b100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          all_d3 = 1'b0, turnoff = 1'b0, l23_ready = 1'b0, xfer = 1'b0;
  logic [NH-1:0] host_evt = '0;
  logic [NF-1:0] wake = '0;
  logic [2:0]    code;
  logic          ack, enter;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lpm_link_seq #(.NUM_FUNC(NF), .NUM_HOST_EVT(NH)) u0 (
    .clk(clk), .rst_n(rst_n), .all_d3_i(all_d3), .turnoff_rx_i(turnoff),
    .l23_ready_i(l23_ready), .xfer_pend_i(xfer), .host_evt_i(host_evt),
    .wake_req_i(wake), .link_state_o(code), .ack_tx_o(ack), .enter_l23_o(enter)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; all_d3 = 0; turnoff = 0; l23_ready = 0; xfer = 0;
    host_evt = '0; wake = '0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "reset code", code, C_L0);
    chk("R1", "reset ack", ack, 0);
    chk("R1", "reset enter", enter, 0);
  endtask

  task automatic t_enter_l1();
    do_reset();
    all_d3 = 1; xfer = 1;
    tick();
    chk("R8", "L1 entry despite xfer pending", code, C_L1);
    xfer = 0;
    tick();
    chk("R2", "L1 held", code, C_L1);
  endtask

  task automatic t_exits();
    do_reset();
    all_d3 = 1; tick();
    chk("R2", "L1 entered", code, C_L1);
    for (int i = 0; i < NH; i++) begin
      host_evt = '0; host_evt[i] = 1'b1; tick();
      chk("R3", "host event exit", code, C_L0);
      host_evt = '0; tick();
      chk("R7", "re-enter L1 after host event", code, C_L1);
    end
    for (int i = 0; i < NF; i += 3) begin
      wake = '0; wake[i] = 1'b1; tick();
      chk("R3", "wake exit", code, C_L0);
      wake = '0; tick();
      chk("R3", "re-enter L1 after wake", code, C_L1);
    end
    all_d3 = 0; tick();
    chk("R3", "D0 exit", code, C_L0);
    tick();
    chk("R3", "stays L0 in D0", code, C_L0);
  endtask

  task automatic t_xfer();
    do_reset();
    all_d3 = 1; tick();
    xfer = 1; tick();
    chk("R7", "xfer exits L1", code, C_L0);
    xfer = 0; tick();
    chk("R7", "back to L1 while D3", code, C_L1);
  endtask

  task automatic t_shutdown();
    do_reset();
    all_d3 = 1; tick();
    turnoff = 1; host_evt = '1; wake = '1; tick();
    chk("R10", "turnoff wins, ack", ack, 1);
    chk("R4", "code during ack", code, C_L0);
    turnoff = 0; host_evt = '0; wake = '0; tick();
    chk("R4", "ack one cycle", ack, 0);
    chk("R9", "code in wait with D3", code, C_L0);
    for (int i = 0; i < 4; i++) begin
      turnoff = (i == 1); wake = (i == 2) ? '1 : '0; xfer = (i == 3);
      tick();
      chk("R5", "enter held without ready", enter, 0);
      chk("R9", "no second ack", ack, 0);
      chk("R9", "code held", code, C_L0);
    end
    turnoff = 0; wake = '0; xfer = 0;
    l23_ready = 1; tick();
    chk("R5", "enter after ready", enter, 1);
    l23_ready = 0; tick();
    chk("R6", "enter one cycle", enter, 0);
    chk("R6", "park code", code, C_L23);
    all_d3 = 0; turnoff = 1; host_evt = '1; tick();
    turnoff = 0; tick();
    chk("R6", "park holds", code, C_L23);
    chk("R6", "no ack in park", ack, 0);
    do_reset();
    chk("R1", "reset leaves park", code, C_L0);
  endtask

  task automatic t_shutdown_ready_early();
    do_reset();
    l23_ready = 1;
    turnoff = 1; tick();
    turnoff = 0;
    chk("R4", "ack from L0", ack, 1);
    tick();
    chk("R5", "no enter in first wait cycle", enter, 0);
    tick();
    chk("R5", "enter two cycles after ack", enter, 1);
    tick();
    chk("R6", "park after early ready", code, C_L23);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_enter_l1();
    t_exits();
    t_xfer();
    t_shutdown();
    t_shutdown_ready_early();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule